// File: doc/BRIEF.md
# Coherent TLB with Peer Tag Invalidation

This block is the address translation buffer of one core in a multi-core system that keeps translations coherent in hardware. A fully associative unified table of 16 translation entries sits behind a 2-entry shadow table. A lookup presents a virtual tag and a process number and gets back, one cycle later, a hit flag, the physical page number and a flag that says whether the shadow table served it. A miss is only reported; walking the page table and raising exceptions are left to the core.

Software loads entries through a write port. When it writes an entry with the valid flag at zero, that entry is dropped locally and the block sends an invalidate message to its peers that carries the written virtual tag. In the other direction, an invalidate message arriving from a peer removes every unified entry with that tag, whatever process owns it, and empties the whole shadow table. This takes a fixed match cycle and a fixed clear cycle, and then an acknowledge pulse goes back to the sender. While a peer invalidate is being taken or processed, the block holds off local lookups and writes. The requester keeps them asserted, and they are carried out as soon as the block is ready again.

Top module: `coh_tlb`

## Requirements
- R1: While reset is asserted and just after it, no entry is valid, portReady is 1, and resValid, resHit, resShadow, invOutValid and rinvAck are 0.
- R2: A lookup is accepted on a clock edge where lookupValid and portReady are both 1. Its result is shown during the next cycle on resValid=1 and resHit. An entry hits when it is valid, its tag equals lookupTag, and its process number equals lookupPid or is zero (zero marks a global entry). When several unified entries hit, the lowest index wins. resPpn carries the hit entry's page number, or zero on a miss.
- R3: A lookup that misses the shadow table but hits the unified table copies the entry into the shadow table. The slots are used in turn, starting with slot 0. A later lookup served by the shadow table reports resShadow=1.
- R4: An accepted write (wrEn with portReady) stores tag, process number, page number and valid flag at wrIdx and empties the whole shadow table. A lookup in the same cycle sees the old contents and does no refill.
- R5: An accepted write with wrValid=0 leaves entry wrIdx invalid. In the next cycle invOutValid is 1 for one cycle and invOutTag equals the written wrTag. A later lookup of that entry misses.
- R6: A peer invalidate clears every unified entry whose tag equals rinvTag, whatever its process number, and leaves entries with other tags unchanged. A later lookup of a cleared entry misses.
- R7: A peer invalidate empties the whole shadow table, including entries whose tag differs from rinvTag. The next hit on such an entry reports resShadow=0.
- R8: A peer invalidate sampled on edge k is matched on edge k+1 and takes effect on edge k+2. rinvAck is 1 for exactly the cycle after edge k+2. This also holds when no entry matches.
- R9: portReady is 0 while rinvValid is 1 and during the match and clear cycles. A lookup or write presented then is not taken. It is taken on the first edge with portReady=1 if still held, so a lookup that arrives together with an invalidate sees the table after the clear. rinvValid is only taken while no invalidate is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Lookup request, held until taken |
| lookupTag | input | VTAG_W | Virtual tag to translate |
| lookupPid | input | PID_W | Process number of the lookup |
| portReady | output | 1 | Lookups and writes are taken this cycle |
| resValid | output | 1 | Lookup result valid |
| resHit | output | 1 | Lookup hit |
| resShadow | output | 1 | Hit served from the shadow table |
| resPpn | output | PPN_W | Physical page number, zero on miss |
| wrEn | input | 1 | Entry write request, held until taken |
| wrIdx | input | log2(UENT) | Unified entry index to write |
| wrTag | input | VTAG_W | Virtual tag to store |
| wrPid | input | PID_W | Process number to store, zero for global |
| wrPpn | input | PPN_W | Physical page number to store |
| wrValid | input | 1 | Valid flag to store |
| invOutValid | output | 1 | Outgoing invalidate message |
| invOutTag | output | VTAG_W | Tag of the outgoing invalidate |
| rinvValid | input | 1 | Incoming peer invalidate |
| rinvTag | input | VTAG_W | Tag of the incoming invalidate |
| rinvAck | output | 1 | Peer invalidate completed |

## Verification
Lookups are tried against entries with the same tag under different process numbers, a global entry, a pair of entries that hit together, and the highest index. This separates the tag-and-process match from the priority order. Repeating a lookup shows the shadow refill and the rotation through the slots, and writes placed between lookups show the shadow flush. A peer invalidate aimed at a tag shared by three processes shows that the process number plays no part. Checking another tag afterwards shows that entries are left alone while the shadow is still emptied. A lookup that arrives together with an invalidate, and an invalidate that matches nothing, exercise the stall timing and the acknowledge.

// File: rtl/coh_tlb_pkg.sv
package coh_tlb_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic lookupGo;   // lookup accepted this cycle
    logic writeGo;    // entry write accepted this cycle
    logic capTag;     // capture incoming invalidate tag
    logic matchGo;    // compare captured tag against all entries
    logic clearGo;    // clear matched entries, empty shadow
  } tlbStrobe_t;

  typedef enum logic [1:0] {
    INV_IDLE  = 2'd0,
    INV_MATCH = 2'd1,
    INV_CLEAR = 2'd2
  } invState_t;

endpackage

// File: rtl/coh_tlb_ctrl.sv
module coh_tlb_ctrl
  import coh_tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lookupValid,
  input  logic       wrEn,
  input  logic       rinvValid,
  output tlbStrobe_t strobe,
  output logic       portReady,
  output logic       rinvAck
);

  invState_t state, stateNext;

  // Local traffic only flows when no peer invalidate is arriving or running
  always_comb begin
    portReady        = (state == INV_IDLE) && !rinvValid;
    strobe.lookupGo  = lookupValid && portReady;
    strobe.writeGo   = wrEn && portReady;
    strobe.capTag    = (state == INV_IDLE) && rinvValid;
    strobe.matchGo   = (state == INV_MATCH);
    strobe.clearGo   = (state == INV_CLEAR);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      INV_IDLE:  if (rinvValid) stateNext = INV_MATCH;
      INV_MATCH: stateNext = INV_CLEAR;
      INV_CLEAR: stateNext = INV_IDLE;
      default:   stateNext = INV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= INV_IDLE;
      rinvAck <= 1'b0;
    end else begin
      state   <= stateNext;
      rinvAck <= strobe.clearGo;
    end
  end

endmodule

// File: rtl/coh_tlb_dp.sv
module coh_tlb_dp
  import coh_tlb_pkg::*;
#(
  parameter int UENT   = 16,
  parameter int SENT   = 2,
  parameter int VTAG_W = 20,
  parameter int PID_W  = 8,
  parameter int PPN_W  = 20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tlbStrobe_t              strobe,
  input  logic [VTAG_W-1:0]       lookupTag,
  input  logic [PID_W-1:0]        lookupPid,
  input  logic [$clog2(UENT)-1:0] wrIdx,
  input  logic [VTAG_W-1:0]       wrTag,
  input  logic [PID_W-1:0]        wrPid,
  input  logic [PPN_W-1:0]        wrPpn,
  input  logic                    wrValid,
  input  logic [VTAG_W-1:0]       rinvTag,
  output logic                    resValid,
  output logic                    resHit,
  output logic                    resShadow,
  output logic [PPN_W-1:0]        resPpn,
  output logic                    invOutValid,
  output logic [VTAG_W-1:0]       invOutTag
);

  localparam int UIDX_W = $clog2(UENT);
  localparam int SIDX_W = (SENT > 1) ? $clog2(SENT) : 1;

  // Unified table
  logic [UENT-1:0]   uValid;
  logic [VTAG_W-1:0] uTag [UENT];
  logic [PID_W-1:0]  uPid [UENT];
  logic [PPN_W-1:0]  uPpn [UENT];
  logic [UENT-1:0]   uHitVec;
  logic [UENT-1:0]   matchVec;

  // Shadow table
  logic [SENT-1:0]   sValid;
  logic [VTAG_W-1:0] sTag [SENT];
  logic [PID_W-1:0]  sPid [SENT];
  logic [PPN_W-1:0]  sPpn [SENT];
  logic [SENT-1:0]   sHitVec;
  logic [SIDX_W-1:0] victim;

  logic [VTAG_W-1:0] capTagQ;
  logic              uHit, sHit;
  logic [UIDX_W-1:0] uSel;
  logic [SIDX_W-1:0] sSel;
  logic              refill;
  logic [PPN_W-1:0]  hitPpn;

  genvar gi;
  generate
    for (gi = 0; gi < UENT; gi++) begin : gUnified
      assign uHitVec[gi] = uValid[gi] && (uTag[gi] == lookupTag) &&
                           ((uPid[gi] == '0) || (uPid[gi] == lookupPid));

      // Remote compare ignores the process number
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               matchVec[gi] <= 1'b0;
        else if (strobe.matchGo) matchVec[gi] <= (uTag[gi] == capTagQ);
      end
    end

    for (gi = 0; gi < SENT; gi++) begin : gShadow
      assign sHitVec[gi] = sValid[gi] && (sTag[gi] == lookupTag) &&
                           ((sPid[gi] == '0) || (sPid[gi] == lookupPid));
    end
  endgenerate

  // Lowest index wins in both tables
  always_comb begin
    uHit = 1'b0;
    uSel = '0;
    for (int i = UENT - 1; i >= 0; i--) begin
      if (uHitVec[i]) begin
        uHit = 1'b1;
        uSel = UIDX_W'(i);
      end
    end
  end

  always_comb begin
    sHit = 1'b0;
    sSel = '0;
    for (int j = SENT - 1; j >= 0; j--) begin
      if (sHitVec[j]) begin
        sHit = 1'b1;
        sSel = SIDX_W'(j);
      end
    end
  end

  assign hitPpn = sHit ? sPpn[sSel] : uPpn[uSel];
  assign refill = strobe.lookupGo && !sHit && uHit && !strobe.writeGo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capTagQ <= '0;
    else if (strobe.capTag) capTagQ <= rinvTag;
  end

  // Unified table update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uValid <= '0;
      for (int i = 0; i < UENT; i++) begin
        uTag[i] <= '0;
        uPid[i] <= '0;
        uPpn[i] <= '0;
      end
    end else if (strobe.writeGo) begin
      uValid[wrIdx] <= wrValid;
      uTag[wrIdx]   <= wrTag;
      uPid[wrIdx]   <= wrPid;
      uPpn[wrIdx]   <= wrPpn;
    end else if (strobe.clearGo) begin
      uValid <= uValid & ~matchVec;
    end
  end

  // Shadow table update: any change to the unified table empties it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sValid <= '0;
      victim <= '0;
      for (int j = 0; j < SENT; j++) begin
        sTag[j] <= '0;
        sPid[j] <= '0;
        sPpn[j] <= '0;
      end
    end else if (strobe.writeGo || strobe.clearGo) begin
      sValid <= '0;
    end else if (refill) begin
      sValid[victim] <= 1'b1;
      sTag[victim]   <= uTag[uSel];
      sPid[victim]   <= uPid[uSel];
      sPpn[victim]   <= uPpn[uSel];
      victim         <= (victim == SIDX_W'(SENT - 1)) ? '0 : victim + 1'b1;
    end
  end

  // Registered lookup result and outgoing message
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      resHit      <= 1'b0;
      resShadow   <= 1'b0;
      resPpn      <= '0;
      invOutValid <= 1'b0;
      invOutTag   <= '0;
    end else begin
      resValid    <= strobe.lookupGo;
      resHit      <= strobe.lookupGo && (sHit || uHit);
      resShadow   <= strobe.lookupGo && sHit;
      resPpn      <= (strobe.lookupGo && (sHit || uHit)) ? hitPpn : '0;
      invOutValid <= strobe.writeGo && !wrValid;
      if (strobe.writeGo) invOutTag <= wrTag;
    end
  end

endmodule

// File: rtl/coh_tlb.sv
module coh_tlb
  import coh_tlb_pkg::*;
#(
  parameter int UENT   = 16,
  parameter int SENT   = 2,
  parameter int VTAG_W = 20,
  parameter int PID_W  = 8,
  parameter int PPN_W  = 20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lookupValid,
  input  logic [VTAG_W-1:0]       lookupTag,
  input  logic [PID_W-1:0]        lookupPid,
  output logic                    portReady,
  output logic                    resValid,
  output logic                    resHit,
  output logic                    resShadow,
  output logic [PPN_W-1:0]        resPpn,
  input  logic                    wrEn,
  input  logic [$clog2(UENT)-1:0] wrIdx,
  input  logic [VTAG_W-1:0]       wrTag,
  input  logic [PID_W-1:0]        wrPid,
  input  logic [PPN_W-1:0]        wrPpn,
  input  logic                    wrValid,
  output logic                    invOutValid,
  output logic [VTAG_W-1:0]       invOutTag,
  input  logic                    rinvValid,
  input  logic [VTAG_W-1:0]       rinvTag,
  output logic                    rinvAck
);

  tlbStrobe_t strobe;

  coh_tlb_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .wrEn        (wrEn),
    .rinvValid   (rinvValid),
    .strobe      (strobe),
    .portReady   (portReady),
    .rinvAck     (rinvAck)
  );

  coh_tlb_dp #(
    .UENT   (UENT),
    .SENT   (SENT),
    .VTAG_W (VTAG_W),
    .PID_W  (PID_W),
    .PPN_W  (PPN_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .lookupTag   (lookupTag),
    .lookupPid   (lookupPid),
    .wrIdx       (wrIdx),
    .wrTag       (wrTag),
    .wrPid       (wrPid),
    .wrPpn       (wrPpn),
    .wrValid     (wrValid),
    .rinvTag     (rinvTag),
    .resValid    (resValid),
    .resHit      (resHit),
    .resShadow   (resShadow),
    .resPpn      (resPpn),
    .invOutValid (invOutValid),
    .invOutTag   (invOutTag)
  );

endmodule

// File: rtl/coh_tlb_chk.sv
module coh_tlb_chk #(
  parameter int PPN_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic             portReady,
  input logic             resValid,
  input logic             resHit,
  input logic             resShadow,
  input logic [PPN_W-1:0] resPpn,
  input logic             wrEn,
  input logic             wrValid,
  input logic             invOutValid,
  input logic             rinvValid,
  input logic             rinvAck
);

  // R8
  ack_after_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rinvAck |-> $past(rinvValid, 3));

  // R8
  busy_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    rinvAck |-> (!$past(portReady, 1) && !$past(portReady, 2)));

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rinvAck |=> !rinvAck);

  // R2
  result_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(lookupValid && portReady));

  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resPpn == '0));

  // R3
  shadow_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    resShadow |-> (resHit && resValid));

  // R5
  inv_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    invOutValid |-> $past(wrEn && portReady && !wrValid));

  // R9
  held_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !portReady) |=> !resValid);

endmodule

bind coh_tlb coh_tlb_chk #(.PPN_W(PPN_W)) uChk (.*);

// File: tb/sim_coh_tlb.sv
module sim_coh_tlb;

  localparam int UENT = 16;
  localparam int SENT = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lookupValid;
  logic [19:0] lookupTag;
  logic [7:0]  lookupPid;
  logic        portReady, resValid, resHit, resShadow;
  logic [19:0] resPpn;
  logic        wrEn;
  logic [3:0]  wrIdx;
  logic [19:0] wrTag;
  logic [7:0]  wrPid;
  logic [19:0] wrPpn;
  logic        wrValid;
  logic        invOutValid;
  logic [19:0] invOutTag;
  logic        rinvValid;
  logic [19:0] rinvTag;
  logic        rinvAck;

  always #4 clk = ~clk;

  coh_tlb u0 (.*);

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          mV [UENT];
  logic [19:0] mTag [UENT];
  logic [7:0]  mPid [UENT];
  logic [19:0] mPpn [UENT];
  bit          sV [SENT];
  logic [19:0] sTag [SENT];
  logic [7:0]  sPid [SENT];
  logic [19:0] sPpn [SENT];
  int          vic, phase;
  logic [19:0] capT;
  bit          eResV, eResHit, eResSh, eInvV, eAck, eReady;
  logic [19:0] eResPpn, eInvTag;

  task automatic modelReset();
    for (int i = 0; i < UENT; i++) begin
      mV[i] = 0; mTag[i] = '0; mPid[i] = '0; mPpn[i] = '0;
    end
    for (int j = 0; j < SENT; j++) begin
      sV[j] = 0; sTag[j] = '0; sPid[j] = '0; sPpn[j] = '0;
    end
    vic = 0; phase = 0; capT = '0;
    eResV = 0; eResHit = 0; eResSh = 0; eResPpn = '0;
    eInvV = 0; eInvTag = '0; eAck = 0;
  endtask

  always @(posedge clk) begin
    bit rdy, sh, uh;
    int ss, us;
    if (!rstN) begin
      modelReset();
    end else begin
      rdy = (phase == 0) && !rinvValid;
      sh = 0; uh = 0; ss = 0; us = 0;
      for (int j = 0; j < SENT; j++)
        if (!sh && sV[j] && sTag[j] == lookupTag && (sPid[j] == 0 || sPid[j] == lookupPid)) begin
          sh = 1; ss = j;
        end
      for (int i = 0; i < UENT; i++)
        if (!uh && mV[i] && mTag[i] == lookupTag && (mPid[i] == 0 || mPid[i] == lookupPid)) begin
          uh = 1; us = i;
        end
      eResV   = rdy && lookupValid;
      eResHit = eResV && (sh || uh);
      eResSh  = eResV && sh;
      eResPpn = !eResHit ? 20'h0 : (sh ? sPpn[ss] : mPpn[us]);
      eInvV   = rdy && wrEn && !wrValid;
      if (rdy && wrEn) eInvTag = wrTag;
      eAck = (phase == 2);
      if (phase == 2) begin
        for (int i = 0; i < UENT; i++) if (mTag[i] == capT) mV[i] = 0;
        for (int j = 0; j < SENT; j++) sV[j] = 0;
        phase = 0;
      end else if (phase == 1) begin
        phase = 2;
      end else if (rinvValid) begin
        capT = rinvTag;
        phase = 1;
      end
      if (rdy && wrEn) begin
        mV[wrIdx] = wrValid; mTag[wrIdx] = wrTag; mPid[wrIdx] = wrPid; mPpn[wrIdx] = wrPpn;
        for (int j = 0; j < SENT; j++) sV[j] = 0;
      end else if (eResV && !sh && uh) begin
        sV[vic] = 1; sTag[vic] = mTag[us]; sPid[vic] = mPid[us]; sPpn[vic] = mPpn[us];
        vic = (vic + 1) % SENT;
      end
    end
    #3;
    if (rstN && !done) begin
      eReady = (phase == 0) && !rinvValid;
      chkEq("R9 ready", portReady, eReady);
      chkEq("R2 resValid", resValid, eResV);
      chkEq("R2 resHit", resHit, eResHit);
      chkEq("R3 resShadow", resShadow, eResSh);
      chkEq("R2 resPpn", resPpn, eResPpn);
      chkEq("R5 invOutValid", invOutValid, eInvV);
      if (eInvV) chkEq("R5 invOutTag", invOutTag, eInvTag);
      chkEq("R8 rinvAck", rinvAck, eAck);
    end
  end

  task automatic doWrite(input int idx, input logic [19:0] tag, input logic [7:0] pid,
                         input logic [19:0] ppn, input bit v);
    @(negedge clk);
    wrEn = 1; wrIdx = idx[3:0]; wrTag = tag; wrPid = pid; wrPpn = ppn; wrValid = v;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic doLookup(input logic [19:0] tag, input logic [7:0] pid, input bit expHit,
                          input bit expSh, input logic [19:0] expPpn, input string req);
    @(negedge clk);
    lookupValid = 1; lookupTag = tag; lookupPid = pid;
    @(negedge clk);
    lookupValid = 0;
    chkEq(req, resValid, 1);
    chkEq(req, resHit, expHit);
    chkEq(req, resShadow, expSh);
    chkEq(req, resPpn, expPpn);
  endtask

  task automatic doRemote(input logic [19:0] tag);
    @(negedge clk);
    rinvValid = 1; rinvTag = tag;
    #1 chkEq("R9 ready low with rinvValid", portReady, 0);
    @(negedge clk);
    rinvValid = 0;
    chkEq("R8 match cycle busy", portReady, 0);
    chkEq("R8 no early ack", rinvAck, 0);
    @(negedge clk);
    chkEq("R8 clear cycle busy", portReady, 0);
    chkEq("R8 no early ack", rinvAck, 0);
    @(negedge clk);
    chkEq("R8 ack pulse", rinvAck, 1);
    chkEq("R8 ready again", portReady, 1);
    @(negedge clk);
    chkEq("R8 ack one cycle", rinvAck, 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; lookupValid = 0; lookupTag = '0; lookupPid = '0;
    wrEn = 0; wrIdx = '0; wrTag = '0; wrPid = '0; wrPpn = '0; wrValid = 0;
    rinvValid = 0; rinvTag = '0;
    repeat (3) @(negedge clk);
    chkEq("R1 ready", portReady, 1);
    chkEq("R1 resValid", resValid, 0);
    chkEq("R1 invOutValid", invOutValid, 0);
    chkEq("R1 rinvAck", rinvAck, 0);
    rstN = 1;
    doLookup(20'h00000, 8'd0, 0, 0, 20'h0, "R1 empty after reset");

    doWrite(0,  20'h00100, 8'd3, 20'h00AAA, 1);
    doWrite(1,  20'h00100, 8'd5, 20'h00BBB, 1);
    doWrite(2,  20'h00200, 8'd0, 20'h00CCC, 1);
    doWrite(3,  20'h00300, 8'd3, 20'h00DDD, 1);
    doWrite(15, 20'h00400, 8'd7, 20'h00EEE, 1);

    doLookup(20'h00100, 8'd3, 1, 0, 20'h00AAA, "R2 tag and pid hit");
    doLookup(20'h00100, 8'd3, 1, 1, 20'h00AAA, "R3 shadow hit");
    doLookup(20'h00100, 8'd5, 1, 0, 20'h00BBB, "R2 other pid");
    doLookup(20'h00100, 8'd9, 0, 0, 20'h0,     "R2 pid mismatch miss");
    doLookup(20'h00200, 8'd9, 1, 0, 20'h00CCC, "R2 global entry");
    doLookup(20'h00400, 8'd7, 1, 0, 20'h00EEE, "R2 top index");
    doLookup(20'h00400, 8'd7, 1, 1, 20'h00EEE, "R3 second slot");

    doWrite(5, 20'h00100, 8'd0, 20'h00555, 1);
    doLookup(20'h00100, 8'd3, 1, 0, 20'h00AAA, "R2 lowest index wins");
    doLookup(20'h00100, 8'd9, 1, 0, 20'h00555, "R2 global behind");

    doWrite(6, 20'h00600, 8'd1, 20'h00666, 1);
    doLookup(20'h00400, 8'd7, 1, 0, 20'h00EEE, "R4 write empties shadow");

    doWrite(3, 20'h00300, 8'd3, 20'h0, 0);
    chkEq("R5 invOutValid", invOutValid, 1);
    chkEq("R5 invOutTag", invOutTag, 20'h00300);
    @(negedge clk);
    chkEq("R5 single pulse", invOutValid, 0);
    doLookup(20'h00300, 8'd3, 0, 0, 20'h0, "R5 invalidated entry misses");

    doLookup(20'h00400, 8'd7, 1, 0, 20'h00EEE, "R3 refill");
    doLookup(20'h00400, 8'd7, 1, 1, 20'h00EEE, "R3 from shadow");
    doRemote(20'h00100);
    doLookup(20'h00400, 8'd7, 1, 0, 20'h00EEE, "R7 shadow emptied");
    doLookup(20'h00100, 8'd3, 0, 0, 20'h0, "R6 pid 3 cleared");
    doLookup(20'h00100, 8'd5, 0, 0, 20'h0, "R6 pid 5 cleared");
    doLookup(20'h00100, 8'd9, 0, 0, 20'h0, "R6 global cleared");
    doLookup(20'h00200, 8'd1, 1, 0, 20'h00CCC, "R6 other tag kept");
    doLookup(20'h00600, 8'd1, 1, 0, 20'h00666, "R6 other tag kept");

    // Lookup and invalidate together: invalidate first, lookup retried
    doWrite(8, 20'h00500, 8'd2, 20'h00123, 1);
    @(negedge clk);
    lookupValid = 1; lookupTag = 20'h00500; lookupPid = 8'd2;
    rinvValid = 1; rinvTag = 20'h00500;
    @(negedge clk);
    rinvValid = 0;
    chkEq("R9 lookup held", resValid, 0);
    @(negedge clk);
    chkEq("R9 lookup held", resValid, 0);
    @(negedge clk);
    chkEq("R9 lookup held", resValid, 0);
    chkEq("R9 ack during hold", rinvAck, 1);
    @(negedge clk);
    lookupValid = 0;
    chkEq("R9 retried lookup", resValid, 1);
    chkEq("R9 sees cleared table", resHit, 0);

    doRemote(20'h00777);
    doLookup(20'h00600, 8'd1, 1, 0, 20'h00666, "R8 no-match invalidate");

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule